// File: doc/BRIEF.md
# Watch Engine Allocator

This block shares four watch engines among software agents through a semaphore that allocates on read. When software reads the allocation register, it gets the ID of an engine it may use. In the same access, that engine is recorded as busy. If no engine is both permitted and idle, the read returns the code 0xFF and nothing changes. A configuration register holds a 4-bit permission mask that limits which engines can be granted. Its value is fixed at reset, and software writes to it have no effect.

Each engine has one bit in an internal busy vector, and the mapping is reversed: bit b belongs to engine 3 − b. Allocation is a priority scan from bit 3 down to bit 0. The first bit that is permitted and idle wins. The neighbouring watch window sends a release strobe with an engine ID when that engine's window is closed, and the release frees the engine. Reads are combinational: the result appears on the read data bus in the same cycle as the read strobe. The busy state updates on the next rising clock edge.

Top module: `watch_engine_alloc`

## Requirements
- R1: After a synchronous active-high reset, every engine is idle and the permission mask is 4'b0111.
- R2: A read with `rd_en`=1 and `rd_sel`=0 (allocation register) scans busy bits from bit 3 down to bit 0. It takes the first bit that is set in the mask and clear in the busy vector, returns 3 − b on `rd_data[7:0]`, and marks that bit busy at the next clock edge.
- R3: An allocation read that finds no engine both permitted and idle returns 8'hFF and leaves the busy vector unchanged.
- R4: A release (`rel_en`=1, `rel_id`=e) clears busy bit 3 − e. Releasing an engine that is already idle has no effect.
- R5: With the reset mask, engine 0 is never granted, and successive grants come out as 1, 2, 3.
- R6: A read with `rd_sel`=1 (configuration register) returns the stored 4-bit mask in `rd_data[3:0]`.
- R7: Writes on `cfg_wr_en`/`cfg_wr_data` leave the mask unchanged.
- R8: When a release and an allocation read fall in the same cycle, the release is applied first, so the engine being released can be granted by that read.
- R9: `rd_data` is 64 bits wide and every bit above the returned field is zero. `rd_data` is all zeros when `rd_en`=0.
- R10: Only an allocation read that succeeds changes the busy state. A configuration read and an idle cycle allocate nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | 0 = allocation register, 1 = configuration register |
| rd_data | output | 64 | Read result, valid in the same cycle as rd_en |
| cfg_wr_en | input | 1 | Configuration write strobe (ignored) |
| cfg_wr_data | input | 4 | Configuration write data (ignored) |
| rel_en | input | 1 | Release strobe from the watch window |
| rel_id | input | 2 | Engine being released |

## Verification
The hardest case to reach is a release and an allocation read in the same cycle while every permitted engine is busy. The grant can only succeed if the release is seen first. The stimulus table reaches this case by first exhausting all permitted engines until the read returns 0xFF. It then pairs a release of engine 3 with an allocation read in one cycle and expects 3 back. It also releases engine 0, which is never granted, and checks that the next read still returns 0xFF.

// File: rtl/wea_pkg.sv
package wea_pkg;
    parameter int unsigned NUM_ENG  = 4;
    parameter int unsigned DATA_W   = 64;
    parameter int unsigned RES_W    = 8;
    localparam int unsigned ID_W    = $clog2(NUM_ENG);

    typedef logic [NUM_ENG-1:0] eng_mask_t;
    typedef logic [ID_W-1:0]    eng_id_t;

    localparam eng_mask_t   MASK_RESET = 4'b0111;
    localparam logic [RES_W-1:0] NONE_CODE = 8'hFF;

    typedef enum logic {
        SEL_ALLOC  = 1'b0,
        SEL_CONFIG = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic      hit;
        eng_id_t   id;
        eng_mask_t grant;
    } pick_t;

    // busy-vector bit that belongs to an engine ID (reversed mapping)
    function automatic eng_mask_t id_to_bit(eng_id_t id);
        eng_mask_t m;
        m = '0;
        m[NUM_ENG - 1 - int'(id)] = 1'b1;
        return m;
    endfunction

    function automatic eng_id_t bit_to_id(int unsigned b);
        return eng_id_t'(NUM_ENG - 1 - b);
    endfunction
endpackage

// File: rtl/wea_pick.sv
module wea_pick
    import wea_pkg::*;
(
    input  eng_mask_t mask,
    input  eng_mask_t busy,
    output pick_t     pick
);
    eng_mask_t avail;
    assign avail = mask & ~busy;

    // ascending loop: the highest set bit is written last and wins
    always_comb begin
        pick = '0;
        for (int unsigned b = 0; b < NUM_ENG; b++) begin
            if (avail[b]) begin
                pick.hit      = 1'b1;
                pick.id       = bit_to_id(b);
                pick.grant    = '0;
                pick.grant[b] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/wea_busy_track.sv
module wea_busy_track
    import wea_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rel_en,
    input  eng_id_t   rel_id,
    input  logic      take_en,
    input  eng_mask_t take_mask,
    output eng_mask_t busy_q,
    output eng_mask_t busy_eff
);
    eng_mask_t rel_mask;
    eng_mask_t busy_nxt;

    assign rel_mask = rel_en ? id_to_bit(rel_id) : '0;
    // release is folded in before the scan sees the state
    assign busy_eff = busy_q & ~rel_mask;
    assign busy_nxt = busy_eff | (take_en ? take_mask : '0);

    always_ff @(posedge clk) begin
        if (rst) busy_q <= '0;
        else     busy_q <= busy_nxt;
    end

    assert_release_frees_R4: assert property (@(posedge clk) disable iff (rst)
        (rel_en && !take_en) |=> !busy_q[NUM_ENG - 1 - int'($past(rel_id))]);

    assert_take_marks_R2: assert property (@(posedge clk) disable iff (rst)
        take_en |=> ((busy_q & $past(take_mask)) == $past(take_mask)));
endmodule

// File: rtl/wea_cfg_hold.sv
module wea_cfg_hold
    import wea_pkg::*;
#(
    parameter eng_mask_t RESET_MASK = MASK_RESET
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  eng_mask_t wr_data,
    output eng_mask_t mask_q
);
    // the register only ever reloads its reset value; writes do not reach it
    always_ff @(posedge clk) begin
        if (rst) mask_q <= RESET_MASK;
        else     mask_q <= mask_q;
    end

    assert_write_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data != mask_q) |=> (mask_q == $past(mask_q)));
endmodule

// File: rtl/watch_engine_alloc.sv
module watch_engine_alloc
    import wea_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rd_en,
    input  logic                    rd_sel,
    output logic [DATA_W-1:0]       rd_data,
    input  logic                    cfg_wr_en,
    input  logic [NUM_ENG-1:0]      cfg_wr_data,
    input  logic                    rel_en,
    input  logic [ID_W-1:0]         rel_id
);
    eng_mask_t mask_q;
    eng_mask_t busy_q;
    eng_mask_t busy_eff;
    pick_t     pick;
    reg_sel_e  sel;
    logic      alloc_rd;
    logic      take_en;
    logic [RES_W-1:0] alloc_res;

    assign sel      = reg_sel_e'(rd_sel);
    assign alloc_rd = rd_en && (sel == SEL_ALLOC);
    assign take_en  = alloc_rd && pick.hit;

    wea_cfg_hold #(.RESET_MASK(MASK_RESET)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .mask_q  (mask_q)
    );

    wea_busy_track u_busy (
        .clk       (clk),
        .rst       (rst),
        .rel_en    (rel_en),
        .rel_id    (rel_id),
        .take_en   (take_en),
        .take_mask (pick.grant),
        .busy_q    (busy_q),
        .busy_eff  (busy_eff)
    );

    wea_pick u_pick (
        .mask (mask_q),
        .busy (busy_eff),
        .pick (pick)
    );

    assign alloc_res = pick.hit ? RES_W'(pick.id) : NONE_CODE;

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_ALLOC:  rd_data = DATA_W'(alloc_res);
                SEL_CONFIG: rd_data = DATA_W'(mask_q);
            endcase
        end
    end

    assert_none_keeps_state_R3: assert property (@(posedge clk) disable iff (rst)
        (alloc_rd && rd_data[RES_W-1:0] == NONE_CODE && !rel_en) |=> $stable(busy_q));

    assert_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
        rd_data[DATA_W-1:RES_W] == '0);

    assert_grant_permitted_R2: assert property (@(posedge clk) disable iff (rst)
        take_en |-> ((pick.grant & mask_q) != '0 && (pick.grant & busy_eff) == '0
                     && $onehot0(pick.grant)));

    assert_quiet_no_change_R10: assert property (@(posedge clk) disable iff (rst)
        (!take_en && !rel_en) |=> $stable(busy_q));

    assert_never_engine0_R5: assert property (@(posedge clk) disable iff (rst)
        (alloc_rd && !mask_q[NUM_ENG-1]) |-> (rd_data[RES_W-1:0] != '0));
endmodule

// File: tb/sim_watch_engine_alloc.sv
module sim_watch_engine_alloc;
    import wea_pkg::*;

    logic clk = 1'b0;
    logic rst;
    logic rd_en, rd_sel, cfg_wr_en, rel_en;
    logic [DATA_W-1:0] rd_data;
    logic [3:0] cfg_wr_data;
    logic [1:0] rel_id;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;   // 125 MHz

    watch_engine_alloc u0 (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .rel_en(rel_en), .rel_id(rel_id)
    );

    typedef struct packed {
        logic        rel;
        logic [1:0]  rid;
        logic        rd;
        logic        sel;
        logic [63:0] exp;
        logic [7:0]  req;
    } vec_t;

    // encodings: sel 0 = allocation register, 1 = configuration register
    localparam vec_t VEC [15] = '{
        '{1'b0, 2'd0, 1'b1, 1'b0, 64'd1,    8'd5},  // R5 first grant engine 1
        '{1'b0, 2'd0, 1'b1, 1'b0, 64'd2,    8'd2},  // R2 scan continues
        '{1'b0, 2'd0, 1'b1, 1'b0, 64'd3,    8'd2},  // R2 last permitted
        '{1'b0, 2'd0, 1'b1, 1'b0, 64'hFF,   8'd3},  // R3 exhausted
        '{1'b0, 2'd0, 1'b1, 1'b0, 64'hFF,   8'd3},  // R3 still exhausted
        '{1'b1, 2'd2, 1'b0, 1'b0, 64'd0,    8'd9},  // R9 idle bus is zero, release 2
        '{1'b0, 2'd0, 1'b1, 1'b0, 64'd2,    8'd4},  // R4 released engine back
        '{1'b1, 2'd0, 1'b0, 1'b0, 64'd0,    8'd4},  // R4 release idle engine 0
        '{1'b0, 2'd0, 1'b1, 1'b0, 64'hFF,   8'd4},  // R4 no effect
        '{1'b1, 2'd3, 1'b1, 1'b0, 64'd3,    8'd8},  // R8 release before grant
        '{1'b1, 2'd1, 1'b1, 1'b1, 64'd7,    8'd6},  // R6 config read, release 1
        '{1'b0, 2'd0, 1'b1, 1'b0, 64'd1,    8'd10}, // R10 config read took nothing
        '{1'b0, 2'd0, 1'b1, 1'b0, 64'hFF,   8'd10}, // R10
        '{1'b1, 2'd1, 1'b0, 1'b0, 64'd0,    8'd4},  // R4 release 1
        '{1'b1, 2'd1, 1'b1, 1'b0, 64'd1,    8'd8}   // R8 double release then grant
    };

    task automatic check(input logic [63:0] exp, input int req, input string what);
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, rd_data, exp);
        end
    endtask

    task automatic idle();
        rd_en = 0; rd_sel = 0; rel_en = 0; rel_id = 0; cfg_wr_en = 0; cfg_wr_data = 0;
    endtask

    // drive at falling edge, sample 1 ns later, commit at next rising edge
    task automatic step(input logic rl, input logic [1:0] ri, input logic r,
                        input logic s, input logic [63:0] exp, input int req,
                        input string what);
        @(negedge clk);
        rel_en = rl; rel_id = ri; rd_en = r; rd_sel = s;
        #1;
        check(exp, req, what);
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    initial begin
        rst = 1;
        idle();
        do_reset();

        // R1 reset state: mask reads 7, first grant is engine 1
        step(0, 0, 1, 1, 64'd7, 1, "reset mask");
        step(0, 0, 1, 0, 64'd1, 1, "reset busy idle");
        do_reset();

        foreach (VEC[i]) begin
            step(VEC[i].rel, VEC[i].rid, VEC[i].rd, VEC[i].sel, VEC[i].exp,
                 int'(VEC[i].req), "table");
        end

        // R7: attempt to write all-ones mask, then verify mask and grants
        do_reset();
        @(negedge clk);
        idle(); cfg_wr_en = 1; cfg_wr_data = 4'b1111;
        @(negedge clk);
        idle(); cfg_wr_en = 1; cfg_wr_data = 4'b1000;
        step(0, 0, 1, 1, 64'd7, 7, "mask after writes");
        step(0, 0, 1, 0, 64'd1, 7, "grant 1");
        step(0, 0, 1, 0, 64'd2, 7, "grant 2");
        step(0, 0, 1, 0, 64'd3, 7, "grant 3");
        step(0, 0, 1, 0, 64'hFF, 7, "engine 0 still blocked");

        // R1 reset mid-operation frees everything
        do_reset();
        step(0, 0, 1, 0, 64'd1, 1, "grant after reset");
        step(0, 0, 0, 0, 64'd0, 9, "no read gives zero");

        @(negedge clk);
        idle();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule